// File: doc/BRIEF.md
# Prescaled Timer with Capture and Match

A 32-bit timer whose count advances once per prescaler period. The prescaler counts steps from zero up to a programmable limit. In timer mode every bus-clock cycle is a step. In counter mode a step is a chosen edge on one synchronized capture pin. Four match comparators watch the count. On a match, each one can set an interrupt flag, return the count to zero, stop the timer, and drive its own output pin low, high, toggled or unchanged.

Several capture channels synchronize their input pins. Each channel copies the current count into its own register on a rising, falling or either edge, and can flag an interrupt. Software uses a small word-addressed register bus to configure the block, read the count and captured values, and clear the sticky flags. The interrupt line is high while any flag is set.

Register addresses (word index): 0 control, 1 count (read), 2 prescale limit, 3 prescale count (read), 4 match configuration, 5 capture configuration, 6 interrupt flags, 8+i match value i, 12+j capture value j. Control bits: [0] run, [1] software counter reset, [2] counter mode, [5:4] count-source channel, [7:6] count-source edge.

Top module: `ptimer_top`

## Requirements
- R1: With prescale limit P, the count advances once every P+1 steps. The prescale count runs 0..P. After K timer-mode cycles of running from zero, the count reads K/(P+1) and the prescale count reads K mod (P+1).
- R2: While control bit 1 is set, the count and the prescale count both read zero.
- R3: Match i with reset enabled (match configuration bit 3i+1) returns the count to zero at the tick after it reaches match value M. The count then cycles 0..M with a period of (M+1)(P+1) cycles.
- R4: Match i with stop enabled (bit 3i+2) clears control bit 0 when the count reaches its value, and the count stays there.
- R5: On a match, output i takes the action in match configuration bits [16+2i+1:16+2i]: 00 unchanged, 01 low, 10 high, 11 toggle. Without a match the output does not change.
- R6: Match i with interrupt enabled (bit 3i) sets flag bit i of the interrupt register. The flag stays set until 1 is written to that bit. The interrupt line is the OR of all flags.
- R7: Capture channel j copies the count into capture register j on the edge chosen by capture configuration bits [3j+1:3j] (00 none, 01 rising, 10 falling, 11 both). Other transitions leave the register unchanged.
- R8: A capture with its interrupt enabled (bit 3j+2) sets flag bit 4+j.
- R9: In counter mode (control bit 2), a step is an edge on the channel named by control bits [5:4], of the kind named by bits [7:6] using the capture edge codes. An input held at least two cycles high and two cycles low is counted once per pulse.
- R10: In counter mode the source channel never captures, and the other channels keep capturing.
- R11: After reset, the registers read zero, all match outputs are low and the interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cap_in | input | NCAP (4) | Capture / count-source pins |
| mat_out | output | NMAT (4) | Match output pins |
| irq | output | 1 | OR of all interrupt flags |

## Verification
Assertions check on every cycle that the count only steps by one or returns to zero, and that the software reset holds both counters at zero. They also check that a match output moves only on a match event and that high actions land. A stop match must clear run, a capture must take the count of the previous cycle, and a flag can fall only after a 1 is written to its bit. The bench scenarios show the cycle totals that no single-cycle property can: the prescaled advance rate, the match-reset period over random limits and match values, the edge selection of each channel, and the counter mode counting pulses while the source channel stays silent.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  typedef enum logic [1:0] {EDGE_NONE = 2'b00, EDGE_RISE = 2'b01,
                            EDGE_FALL = 2'b10, EDGE_BOTH = 2'b11} edge_t;
  typedef enum logic [1:0] {ACT_KEEP = 2'b00, ACT_LOW = 2'b01,
                            ACT_HIGH = 2'b10, ACT_TOGGLE = 2'b11} act_t;
  localparam int ADDR_W  = 4;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 4'd1;
  localparam logic [ADDR_W-1:0] A_PRE   = 4'd2;
  localparam logic [ADDR_W-1:0] A_PCNT  = 4'd3;
  localparam logic [ADDR_W-1:0] A_MCFG  = 4'd4;
  localparam logic [ADDR_W-1:0] A_CCFG  = 4'd5;
  localparam logic [ADDR_W-1:0] A_IRQ   = 4'd6;
  localparam int MVAL_BASE = 8;
  localparam int CVAL_BASE = 12;
  localparam int ACT_LSB   = 16;
endpackage

// File: rtl/ptimer_capture.sv
module ptimer_capture
  import ptimer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin,
  input  edge_t        sel,
  input  logic         inhibit,
  input  logic [W-1:0] tc,
  output logic         rise,
  output logic         fall,
  output logic         cap_evt,
  output logic [W-1:0] cap_val
);
  logic         s1_q, s2_q, prev_q;
  logic [W-1:0] cap_q, cap_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  always_comb begin
    rise = s2_q & ~prev_q;
    fall = ~s2_q & prev_q;
    unique case (sel)
      EDGE_RISE: cap_evt = rise;
      EDGE_FALL: cap_evt = fall;
      EDGE_BOTH: cap_evt = rise | fall;
      default:   cap_evt = 1'b0;
    endcase
    if (inhibit) cap_evt = 1'b0;
    cap_d = cap_evt ? tc : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= cap_d;
  end

  assign cap_val = cap_q;

  // R7
  cap_takes_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_q == $past(tc)));
  // R10
  cap_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> $stable(cap_q));
endmodule

// File: rtl/ptimer_core.sv
module ptimer_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         swrst,
  input  logic         step,
  input  logic [W-1:0] pr,
  input  logic         zero_hit,
  output logic [W-1:0] tc,
  output logic [W-1:0] pc,
  output logic         tick,
  output logic [W-1:0] tc_nxt
);
  logic [W-1:0] tc_q, tc_d, pc_q, pc_d;

  always_comb begin
    tc_nxt = zero_hit ? '0 : tc_q + 1'b1;
    tick   = en && step && (pc_q >= pr);
    tc_d   = tc_q;
    pc_d   = pc_q;
    if (swrst) begin
      tc_d = '0;
      pc_d = '0;
    end else if (tick) begin
      tc_d = tc_nxt;
      pc_d = '0;
    end else if (en && step) begin
      pc_d = pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q <= '0;
      pc_q <= '0;
    end else begin
      tc_q <= tc_d;
      pc_q <= pc_d;
    end
  end

  assign tc = tc_q;
  assign pc = pc_q;

  // R2
  swrst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst |=> (tc_q == '0 && pc_q == '0));
  // R1
  tc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_q != $past(tc_q)) |-> ((tc_q == $past(tc_q) + 1'b1) || (tc_q == '0)));
endmodule

// File: rtl/ptimer_match.sv
module ptimer_match
  import ptimer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] tc,
  input  logic [W-1:0] tc_nxt,
  input  logic [W-1:0] mr,
  input  act_t         act,
  output logic         hit,
  output logic         evt,
  output logic         out
);
  logic out_q, out_d;

  always_comb begin
    hit   = (tc == mr);
    evt   = tick && (tc_nxt == mr);
    out_d = out_q;
    if (evt) begin
      unique case (act)
        ACT_LOW:    out_d = 1'b0;
        ACT_HIGH:   out_d = 1'b1;
        ACT_TOGGLE: out_d = ~out_q;
        default:    out_d = out_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign out = out_q;

  // R5
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(out_q));
  // R5
  out_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && act == ACT_HIGH) |=> out_q);
endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
  import ptimer_pkg::*;
#(
  parameter int W    = 32,
  parameter int NCAP = 4,
  parameter int NMAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCAP-1:0]   cap_in,
  output logic [NMAT-1:0]   mat_out,
  output logic              irq
);
  localparam int SEL_W = (NCAP > 1) ? $clog2(NCAP) : 1;
  localparam int NFLAG = NMAT + NCAP;

  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  // configuration registers
  logic             run_q, run_d, swrst_q, swrst_d, cmode_q, cmode_d;
  logic [SEL_W-1:0] src_q, src_d;
  edge_t            cedge_q, cedge_d;
  logic [W-1:0]     pr_q, pr_d;
  logic [NMAT-1:0]  m_irq_q, m_irq_d, m_rst_q, m_rst_d, m_stop_q, m_stop_d;
  act_t             m_act_q [NMAT];
  act_t             m_act_d [NMAT];
  logic [W-1:0]     mr_q [NMAT];
  logic [W-1:0]     mr_d [NMAT];
  edge_t            c_edge_q [NCAP];
  edge_t            c_edge_d [NCAP];
  logic [NCAP-1:0]  c_irq_q, c_irq_d;
  logic [NFLAG-1:0] flag_q, flag_d, flag_set, flag_clr;

  // datapath
  logic [W-1:0]     tc, pc, tc_nxt;
  logic             tick, step, zero_hit, stop_hit;
  logic [NMAT-1:0]  m_hit, m_evt;
  logic [NCAP-1:0]  c_rise, c_fall, c_evt, c_inh;
  logic [W-1:0]     cap_val [NCAP];

  logic wr_ctrl, wr_irq;
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_irq  = bus_wr && (bus_addr == A_IRQ);

  always_comb begin
    run_d    = run_q;
    swrst_d  = swrst_q;
    cmode_d  = cmode_q;
    src_d    = src_q;
    cedge_d  = cedge_q;
    pr_d     = pr_q;
    m_irq_d  = m_irq_q;
    m_rst_d  = m_rst_q;
    m_stop_d = m_stop_q;
    c_irq_d  = c_irq_q;
    for (int i = 0; i < NMAT; i++) begin
      m_act_d[i] = m_act_q[i];
      mr_d[i]    = mr_q[i];
    end
    for (int j = 0; j < NCAP; j++) c_edge_d[j] = c_edge_q[j];

    if (stop_hit) run_d = 1'b0;
    if (bus_wr) begin
      if (bus_addr == A_CTRL) begin
        run_d   = bus_wdata[0];
        swrst_d = bus_wdata[1];
        cmode_d = bus_wdata[2];
        src_d   = bus_wdata[4 +: SEL_W];
        cedge_d = edge_t'(bus_wdata[7:6]);
      end
      if (bus_addr == A_PRE) pr_d = bus_wdata[W-1:0];
      if (bus_addr == A_MCFG) begin
        for (int i = 0; i < NMAT; i++) begin
          m_irq_d[i]  = bus_wdata[3*i];
          m_rst_d[i]  = bus_wdata[3*i+1];
          m_stop_d[i] = bus_wdata[3*i+2];
          m_act_d[i]  = act_t'(bus_wdata[ACT_LSB+2*i +: 2]);
        end
      end
      if (bus_addr == A_CCFG) begin
        for (int j = 0; j < NCAP; j++) begin
          c_edge_d[j] = edge_t'(bus_wdata[3*j +: 2]);
          c_irq_d[j]  = bus_wdata[3*j+2];
        end
      end
      for (int i = 0; i < NMAT; i++)
        if (bus_addr == ADDR_W'(MVAL_BASE + i)) mr_d[i] = bus_wdata[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      run_q    <= 1'b0;
      swrst_q  <= 1'b0;
      cmode_q  <= 1'b0;
      src_q    <= '0;
      cedge_q  <= EDGE_NONE;
      pr_q     <= '0;
      m_irq_q  <= '0;
      m_rst_q  <= '0;
      m_stop_q <= '0;
      c_irq_q  <= '0;
      for (int i = 0; i < NMAT; i++) begin
        m_act_q[i] <= ACT_KEEP;
        mr_q[i]    <= '0;
      end
      for (int j = 0; j < NCAP; j++) c_edge_q[j] <= EDGE_NONE;
    end else begin
      run_q    <= run_d;
      swrst_q  <= swrst_d;
      cmode_q  <= cmode_d;
      src_q    <= src_d;
      cedge_q  <= cedge_d;
      pr_q     <= pr_d;
      m_irq_q  <= m_irq_d;
      m_rst_q  <= m_rst_d;
      m_stop_q <= m_stop_d;
      c_irq_q  <= c_irq_d;
      for (int i = 0; i < NMAT; i++) begin
        m_act_q[i] <= m_act_d[i];
        mr_q[i]    <= mr_d[i];
      end
      for (int j = 0; j < NCAP; j++) c_edge_q[j] <= c_edge_d[j];
    end
  end

  // count source selection
  always_comb begin
    step = 1'b1;
    if (cmode_q) begin
      unique case (cedge_q)
        EDGE_RISE: step = c_rise[src_q];
        EDGE_FALL: step = c_fall[src_q];
        EDGE_BOTH: step = c_rise[src_q] | c_fall[src_q];
        default:   step = 1'b0;
      endcase
    end
  end

  assign zero_hit = |(m_hit & m_rst_q);
  assign stop_hit = |(m_evt & m_stop_q);

  ptimer_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_q), .en(run_q && !swrst_q), .swrst(swrst_q),
    .step(step), .pr(pr_q), .zero_hit(zero_hit), .tc(tc), .pc(pc),
    .tick(tick), .tc_nxt(tc_nxt)
  );

  for (genvar i = 0; i < NMAT; i++) begin : g_match
    ptimer_match #(.W(W)) u_match (
      .clk(clk), .rst_n(rst_q), .tick(tick), .tc(tc), .tc_nxt(tc_nxt),
      .mr(mr_q[i]), .act(m_act_q[i]), .hit(m_hit[i]), .evt(m_evt[i]),
      .out(mat_out[i])
    );
  end

  for (genvar j = 0; j < NCAP; j++) begin : g_cap
    assign c_inh[j] = cmode_q && (src_q == SEL_W'(j));
    ptimer_capture #(.W(W)) u_cap (
      .clk(clk), .rst_n(rst_q), .pin(cap_in[j]), .sel(c_edge_q[j]),
      .inhibit(c_inh[j]), .tc(tc), .rise(c_rise[j]), .fall(c_fall[j]),
      .cap_evt(c_evt[j]), .cap_val(cap_val[j])
    );
  end

  // sticky flags, set wins over a clear in the same cycle
  always_comb begin
    flag_set = {c_evt & c_irq_q, m_evt & m_irq_q};
    flag_clr = wr_irq ? bus_wdata[NFLAG-1:0] : '0;
    flag_d   = (flag_q & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign irq = |flag_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL: begin
        bus_rdata[0]           = run_q;
        bus_rdata[1]           = swrst_q;
        bus_rdata[2]           = cmode_q;
        bus_rdata[4 +: SEL_W]  = src_q;
        bus_rdata[7:6]         = cedge_q;
      end
      A_COUNT: bus_rdata[W-1:0] = tc;
      A_PRE:   bus_rdata[W-1:0] = pr_q;
      A_PCNT:  bus_rdata[W-1:0] = pc;
      A_MCFG: begin
        for (int i = 0; i < NMAT; i++) begin
          bus_rdata[3*i]                = m_irq_q[i];
          bus_rdata[3*i+1]              = m_rst_q[i];
          bus_rdata[3*i+2]              = m_stop_q[i];
          bus_rdata[ACT_LSB+2*i +: 2]   = m_act_q[i];
        end
      end
      A_CCFG: begin
        for (int j = 0; j < NCAP; j++) begin
          bus_rdata[3*j +: 2] = c_edge_q[j];
          bus_rdata[3*j+2]    = c_irq_q[j];
        end
      end
      A_IRQ: bus_rdata[NFLAG-1:0] = flag_q;
      default: begin
        for (int i = 0; i < NMAT; i++)
          if (bus_addr == ADDR_W'(MVAL_BASE + i)) bus_rdata[W-1:0] = mr_q[i];
        for (int j = 0; j < NCAP; j++)
          if (bus_addr == ADDR_W'(CVAL_BASE + j)) bus_rdata[W-1:0] = cap_val[j];
      end
    endcase
  end

  // R4
  stop_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (stop_hit && !wr_ctrl) |=> !run_q);

  for (genvar k = 0; k < NFLAG; k++) begin : g_flag_chk
    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_q)
      $fell(flag_q[k]) |-> $past(wr_irq && bus_wdata[k]));
  end
endmodule

// File: tb/tb_ptimer_top.sv
module tb_ptimer_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  cap_in;
  logic [3:0]  mat_out;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptimer_top dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .mat_out(mat_out), .irq(irq)
  );

  function automatic int exp_period(int m, int p);
    return (m + 1) * (p + 1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(logic [31:0] ctrl);
    wr(4'd0, 32'h2);
    wr(4'd0, ctrl);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int m, p, k, maxtc, ch, last, t, per;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; cap_in = '0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    void'($urandom(32'd4242));

    // R11 reset state
    rd(4'd0, v);  chk("R11 ctrl", v, 0);
    rd(4'd1, v);  chk("R11 count", v, 0);
    rd(4'd6, v);  chk("R11 flags", v, 0);
    chk("R11 outputs", {28'd0, mat_out}, 0);
    chk("R11 irq", {31'd0, irq}, 0);

    // R1 prescaled advance, directed then random
    for (int it = 0; it < 4; it++) begin
      p = (it == 0) ? 3 : int'($urandom % 7);
      k = (it == 0) ? 17 : 5 + int'($urandom % 40);
      wr(4'd2, p);
      restart(32'h1);
      idle(k);
      rd(4'd1, v); chk("R1 count", v, k / (p + 1));
      rd(4'd3, v); chk("R1 prescale count", v, k % (p + 1));
    end

    // R2 software reset holds zero
    wr(4'd0, 32'h3);
    idle(5);
    rd(4'd1, v); chk("R2 count held", v, 0);
    rd(4'd3, v); chk("R2 prescale held", v, 0);

    // R3 R5 match reset period with toggle, random limits
    for (int it = 0; it < 4; it++) begin
      m = 2 + int'($urandom % 19);
      p = int'($urandom % 6);
      wr(4'd8, m);
      wr(4'd2, p);
      wr(4'd4, 32'h0003_0002);   // match0: reset, toggle
      restart(32'h1);
      ch = 0; last = 0; per = 0; maxtc = 0;
      bus_addr = 4'd1;
      for (t = 0; t < 2000 && ch < 3; t++) begin
        logic prev;
        prev = mat_out[0];
        @(negedge clk);
        #1;
        if (int'(bus_rdata) > maxtc) maxtc = int'(bus_rdata);
        if (mat_out[0] != prev) begin
          ch++;
          if (ch == 3) per = t - last;
          last = t;
        end
      end
      chk("R3 R5 toggle period", per, exp_period(m, p));
      chk("R3 count ceiling", maxtc, m);
    end

    // R4 R5 R6 stop on match with high action and interrupt
    wr(4'd8, 32'd1000);
    wr(4'd9, 32'd3);
    wr(4'd2, 32'd1);
    wr(4'd4, 32'h0008_0028);     // match1: irq, stop, act high
    restart(32'h1);
    idle(30);
    rd(4'd0, v); chk("R4 run cleared", v & 32'h1, 0);
    rd(4'd1, v); chk("R4 count held", v, 3);
    chk("R5 high action", {31'd0, mat_out[1]}, 1);
    rd(4'd6, v); chk("R6 flag set", v, 32'h2);
    chk("R6 irq high", {31'd0, irq}, 1);
    idle(3);
    rd(4'd6, v); chk("R6 flag sticky", v, 32'h2);
    wr(4'd6, 32'h2);
    rd(4'd6, v); chk("R6 flag cleared", v, 0);
    chk("R6 irq low", {31'd0, irq}, 0);

    // R7 R8 capture edge selection on stopped count (3)
    wr(4'd5, 32'h0000_0606);     // ch0 falling+irq, ch3 both no irq
    cap_in[0] = 1'b1; cap_in[3] = 1'b1;
    idle(5);
    rd(4'd12, v); chk("R7 rising ignored on falling channel", v, 0);
    rd(4'd15, v); chk("R7 both-edge rising capture", v, 3);
    rd(4'd6, v);  chk("R8 no flag yet", v, 0);
    cap_in[0] = 1'b0;
    idle(5);
    rd(4'd12, v); chk("R7 falling capture", v, 3);
    rd(4'd6, v);  chk("R8 capture flag bit4", v, 32'h10);
    wr(4'd6, 32'h10);

    // R5 low action
    wr(4'd4, 32'h0004_0020);     // match1: stop, act low
    restart(32'h1);
    idle(20);
    chk("R5 low action", {31'd0, mat_out[1]}, 0);
    rd(4'd1, v); chk("R4 count held again", v, 3);

    // R9 R10 counter mode, source ch1 rising
    wr(4'd4, 32'h0);
    wr(4'd2, 32'h0);
    wr(4'd5, 32'h0000_0048);     // ch1 rising, ch2 rising
    restart(32'h55);
    for (int n = 0; n < 5; n++) begin
      cap_in[1] = 1'b1; idle(2);
      cap_in[1] = 1'b0; idle(2);
    end
    idle(6);
    rd(4'd1, v);  chk("R9 pulses counted", v, 5);
    rd(4'd13, v); chk("R10 source channel silent", v, 0);
    cap_in[2] = 1'b1;
    idle(5);
    rd(4'd14, v); chk("R10 other channel captures", v, 5);
    rd(4'd1, v);  chk("R9 no count without source edge", v, 5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule